// File: doc/BRIEF.md
# Octal Double-Buffered DAC Code Register Interface

This block is the digital front end of an eight-channel converter. Each channel keeps two registers in a chain. The first is a staging register, which is written from a parallel bus. The second is an output register, which drives that channel's 14-bit code. A 3-bit address picks one staging register. While both active-low select and write strobes are low, that staging register follows the bus. An active-low transfer strobe copies every staging register into its output register at the same moment. An active-low clear makes every channel present the mid-scale ground-offset code, and the stored codes are left as they were.

The control pins behave like levels. They are treated as asynchronous. Every pin passes through a two-flop synchronizer, and the registers then sample the synchronized levels on each system clock edge. This gives the behaviour of a transparent latch in a design that stays synthesizable. When a strobe is released, the register that was open keeps the value from the last cycle in which it was open. When select, write and transfer are all low at once, bus data flows through both stages in a single register update.

Top module: `octal_dac_regs`

## Requirements
- R1: The address selects a staging register in straight binary: 3'b000 selects channel 0 and 3'b111 selects channel 7.
- R2: While cs_n and wr_n are both low, only the addressed staging register takes the bus value. The other seven keep their contents.
- R3: When cs_n or wr_n goes high, the addressed staging register keeps the last bus value it took. Later bus changes do not affect it.
- R4: While ldac_n is high, every output register keeps its contents, including while staging registers are being written.
- R5: While ldac_n is low, all eight output registers follow their staging registers.
- R6: With cs_n, wr_n and ldac_n all low, a bus value appears on the addressed channel's code output on the third rising clock edge after the inputs change, and not before.
- R7: While clr_n is low, every code output reads 14'h2000 and every clear_o bit is 1. This starts on the second rising edge after clr_n falls.
- R8: After clr_n returns high, each code output again shows its output register. Any writes or transfers made while clr_n was low are kept.
- R9: A synchronous reset loads 14'h2000 into all staging and output registers and drives clear_o to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ldac_n | input | 1 | Transfer strobe that updates all channels, active low |
| clr_n | input | 1 | Clear to ground-offset code, active low |
| addr_i | input | 3 | Staging register select |
| data_i | input | 14 | Parallel code bus |
| code_o | output | 112 | Channel codes, channel k in bits [14k+13:14k] |
| clear_o | output | 8 | Per-channel flag, high while the clear is active |

## Verification
The bench goes after the edges where a naive design would misbehave. It moves the bus after select or write has risen; a register left open there would pick up the new value. It writes one channel while the transfer strobe is high; a design that loads the output stage on writes would show the new code too early. It holds a clear while channels are written and transferred; a clear that wipes the registers would come back with mid-scale codes instead of the new data. It also counts edges on the flow-through path and on the clear path, so an extra or missing pipeline stage shows up as the output changing one cycle off.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;

  // Mid-scale code for a given code width (the ground-offset value).
  function automatic logic [31:0] mid_code(input int unsigned w);
    return 32'(1) << (w - 1);
  endfunction

  // Straight-binary channel match for address decode.
  function automatic logic addr_hit(input logic [7:0] a, input int unsigned idx);
    return a == idx[7:0];
  endfunction

endpackage

// File: rtl/dac_sync_stage.sv
`timescale 1ns/1ps
module dac_sync_stage #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dac_in_bank.sv
`timescale 1ns/1ps
module dac_in_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        hit_i,
  input  logic [CODE_W-1:0]        data_i,
  output logic [NUM_CH*CODE_W-1:0] q_o,
  output logic [NUM_CH*CODE_W-1:0] nxt_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(dacif_pkg::mid_code(CODE_W));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // nxt_o is the value the staging register holds after this edge;
    // the output stage reads it so that flow-through needs one update.
    assign nxt_o[i*CODE_W +: CODE_W] = hit_i[i] ? data_i : q_o[i*CODE_W +: CODE_W];

    always_ff @(posedge clk) begin
      if (rst) q_o[i*CODE_W +: CODE_W] <= MID;
      else     q_o[i*CODE_W +: CODE_W] <= nxt_o[i*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/dac_out_bank.sv
`timescale 1ns/1ps
module dac_out_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_i,
  input  logic                     clr_i,
  input  logic [NUM_CH*CODE_W-1:0] nxt_i,
  output logic [NUM_CH*CODE_W-1:0] dac_q_o,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        clear_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(dacif_pkg::mid_code(CODE_W));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       dac_q_o[i*CODE_W +: CODE_W] <= MID;
      else if (ld_i) dac_q_o[i*CODE_W +: CODE_W] <= nxt_i[i*CODE_W +: CODE_W];
    end

    // Clear overrides only the presented code; storage is untouched.
    assign code_o[i*CODE_W +: CODE_W] = clr_i ? MID : dac_q_o[i*CODE_W +: CODE_W];
    assign clear_o[i] = clr_i;
  end
endmodule

// File: rtl/octal_dac_regs.sv
`timescale 1ns/1ps
module octal_dac_regs #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     wr_n,
  input  logic                     ldac_n,
  input  logic                     clr_n,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        data_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        clear_o
);
  localparam int unsigned SYNC_W = 4 + ADDR_W + CODE_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + CODE_W){1'b0}}};

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic cs_s, wr_s, ldac_s, clr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [CODE_W-1:0] data_s;

  // Named internal events, also seen by the bound checker.
  logic                     wr_act;
  logic [NUM_CH-1:0]        wr_hit;
  logic                     ld_act;
  logic                     clr_act;
  logic [NUM_CH*CODE_W-1:0] in_q, in_nxt, dac_q;

  assign raw_bus = {cs_n, wr_n, ldac_n, clr_n, addr_i, data_i};

  dac_sync_stage #(.W(SYNC_W), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst(rst), .d_i(raw_bus), .q_o(sync_bus)
  );

  assign {cs_s, wr_s, ldac_s, clr_s, addr_s, data_s} = sync_bus;

  assign wr_act  = !cs_s && !wr_s;
  assign ld_act  = !ldac_s;
  assign clr_act = !clr_s;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign wr_hit[i] = wr_act && dacif_pkg::addr_hit(8'(addr_s), i);
  end

  dac_in_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) in_bank_i (
    .clk(clk), .rst(rst), .hit_i(wr_hit), .data_i(data_s),
    .q_o(in_q), .nxt_o(in_nxt)
  );

  dac_out_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) out_bank_i (
    .clk(clk), .rst(rst), .ld_i(ld_act), .clr_i(clr_act), .nxt_i(in_nxt),
    .dac_q_o(dac_q), .code_o(code_o), .clear_o(clear_o)
  );
endmodule

// File: rtl/octal_dac_regs_chk.sv
`timescale 1ns/1ps
module octal_dac_regs_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        wr_hit,
  input logic                     ld_act,
  input logic                     clr_act,
  input logic [NUM_CH*CODE_W-1:0] in_q,
  input logic [NUM_CH*CODE_W-1:0] dac_q,
  input logic [NUM_CH*CODE_W-1:0] code_o,
  input logic [NUM_CH-1:0]        clear_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(dacif_pkg::mid_code(CODE_W));

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_hit)); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_hit[i] |=> $stable(in_q[i*CODE_W +: CODE_W])); // R2
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ld_act |=> $stable(dac_q[i*CODE_W +: CODE_W])); // R4
    AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      ld_act |=> dac_q[i*CODE_W +: CODE_W] == in_q[i*CODE_W +: CODE_W]); // R5
    AST_CLR_FORCE: assert property (@(posedge clk) disable iff (rst)
      clr_act |-> (code_o[i*CODE_W +: CODE_W] == MID) && clear_o[i]); // R7
    AST_CLR_PASS: assert property (@(posedge clk) disable iff (rst)
      !clr_act |-> (code_o[i*CODE_W +: CODE_W] == dac_q[i*CODE_W +: CODE_W]) && !clear_o[i]); // R8
  end
endmodule

bind octal_dac_regs octal_dac_regs_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .wr_hit(wr_hit), .ld_act(ld_act), .clr_act(clr_act),
  .in_q(in_q), .dac_q(dac_q), .code_o(code_o), .clear_o(clear_o)
);

// File: tb/octal_dac_regs_tb_top.sv
`timescale 1ns/1ps
module octal_dac_regs_tb_top;
  localparam int NCH = 8;
  localparam int CW  = 14;
  localparam logic [CW-1:0] MID = 14'h2000;

  typedef struct packed {
    logic cs, wr, ld, clr;
    logic [2:0] a;
    logic [CW-1:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 14'h0111, 4'd1}, // R1 write ch0, outputs hold
    '{1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'h3FFF, 4'd3}, // R3 wr released, bus moves
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 14'h1777, 4'd1}, // R1 write ch7
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 14'h0333, 4'd2}, // R2 write ch3 only
    '{1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 14'h2AAA, 4'd3}, // R3 cs released, bus moves
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 14'h2AAA, 4'd5}, // R5 transfer all channels
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000, 4'd4}, // R4 transfer closed
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 14'h0555, 4'd4}, // R4 write with output held
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 14'h0555, 4'd4}, // R4 idle, still held
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 14'h0555, 4'd7}, // R7 clear asserted
    '{1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 14'h0ABC, 4'd7}, // R7 write+transfer under clear
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 14'h0ABC, 4'd7}, // R7 strobes closed, clear held
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 14'h0ABC, 4'd8}, // R8 clear released
    '{1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 14'h3FFF, 4'd6}, // R6 flow-through ch2
    '{1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 14'h1234, 4'd6}, // R6 retarget to ch6
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000, 4'd2}  // R2 all closed
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [CW-1:0] data = '0;
  logic [NCH*CW-1:0] code;
  logic [NCH-1:0] clr_flag;

  logic [CW-1:0] m_in [NCH];
  logic [CW-1:0] m_dac [NCH];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  octal_dac_regs dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n), .clr_n(clr_n),
    .addr_i(addr), .data_i(data), .code_o(code), .clear_o(clr_flag)
  );

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_in[i] = MID; m_dac[i] = MID; end
  endtask

  task automatic model_step();
    if (!cs_n && !wr_n) m_in[addr] = data;
    if (!ldac_n) for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
  endtask

  task automatic check_all(input int req, input string what);
    bit bad = 1'b0;
    tests++;
    for (int i = 0; i < NCH; i++) begin
      logic [CW-1:0] exp_c = clr_n ? m_dac[i] : MID;
      if (!bad && (code[i*CW +: CW] !== exp_c || clr_flag[i] !== !clr_n)) begin
        bad = 1'b1;
        $display("FAIL R%0d %s ch%0d: code=%h exp=%h flag=%b exp=%b", req, what, i,
                 code[i*CW +: CW], exp_c, clr_flag[i], !clr_n);
      end
    end
    if (bad) fails++;
  endtask

  task automatic check_ch(input int req, input string what, input int ch, input logic [CW-1:0] exp_c);
    tests++;
    if (code[ch*CW +: CW] !== exp_c) begin
      fails++;
      $display("FAIL R%0d %s ch%0d: code=%h exp=%h", req, what, ch, code[ch*CW +: CW], exp_c);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..all): cycles=100000 exp=finish earlier");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all(9, "reset state"); // R9

    // Table walk
    for (int v = 0; v < NV; v++) begin
      {cs_n, wr_n, ldac_n, clr_n} = {VECS[v].cs, VECS[v].wr, VECS[v].ld, VECS[v].clr};
      addr = VECS[v].a;
      data = VECS[v].d;
      settle();
      model_step();
      check_all(int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R6 edge count on flow-through path
    {cs_n, wr_n, ldac_n} = 3'b000; addr = 3'd4; data = 14'h0F0F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_ch(6, "flow-through before 3rd edge", 4, m_dac[4]);
    @(posedge clk);
    @(negedge clk);
    check_ch(6, "flow-through at 3rd edge", 4, 14'h0F0F);
    model_step();
    {cs_n, wr_n, ldac_n} = 3'b111;
    settle();

    // R7 edge count on clear path
    clr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (clr_flag !== '0) begin
      fails++;
      $display("FAIL R7 clear after 1st edge: flag=%b exp=%b", clr_flag, 8'h00);
    end
    @(posedge clk);
    @(negedge clk);
    check_all(7, "clear at 2nd edge");
    clr_n = 1'b1;
    settle();
    check_all(8, "restore after clear");

    // R9 reset mid-run wipes stored codes
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    settle();
    check_all(9, "reset after writes");
    ldac_n = 1'b0;
    settle();
    model_step();
    check_all(9, "staging mid after reset");
    ldac_n = 1'b1;
    settle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule